// File: doc/BRIEF.md
# Latency-Insensitive Shell Wrapper

This block surrounds a patient compute core. The core may be paused for any number of cycles without losing its state. The wrapper has a configurable number of input and output channels. Each channel uses a valid/stop handshake.

The wrapper issues a single-cycle enable to the core, which acts as the core's logical clock. It does so only when two things hold in the same cycle:
- every input channel has a token, either arriving now or held from an earlier cycle;
- no output channel reports a stall.

Tokens that arrive early are parked in a one-entry slot per input until the slowest input catches up. An upstream channel is told to hold off only while its own slot is occupied.

The path from the input handshake to the enable, and on to the output valids, is combinational within one cycle. A parked token and a live token reach the core through the same per-input selector.

A small registered stand-in core is included. It merges the selected input words, by sum or XOR as chosen by a parameter. It adds its own count of past firings and then the output channel index.

Top module: `lis_shell`

## Requirements
- R1: The enable is high in a cycle exactly when every input either has `in_valid` high or has its slot occupied, and every bit of `out_stop` is low. It appears on every `out_valid` bit.
- R2: All bits of `out_valid` are equal in every cycle.
- R3: If any bit of `out_stop` is high, every bit of `out_valid` is low in that cycle.
- R4: A token arriving on an empty slot in a cycle without firing is captured. From the next cycle that channel's `in_stop` is high.
- R5: `in_stop[i]` is high exactly while slot i holds an unconsumed token. This includes the cycle in which the wrapper fires. It is never high for a token arriving in the current cycle.
- R6: A firing empties every slot. In the following cycle every `in_stop` is low unless a new token was captured.
- R7: For each input, the core receives the parked word when the slot is occupied and the live `in_data` word otherwise.
- R8: When firing, `out_data` word j equals (merge of the N selected input words) + F + j, modulo 2^DATA_W. F is the number of firings since reset. With the default sum mode, the merge is their sum. Word j occupies bits [j*DATA_W +: DATA_W]. Input word i occupies bits [i*DATA_W +: DATA_W] of `in_data`.
- R9: After reset, all slots are empty, `in_stop` and `out_valid` are low, and the firing count is zero.
- R10: The k-th firing (counting from zero) consumes exactly the k-th token sent on each input. No token is lost or used twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | N_IN | Token present on input channel i |
| in_data | input | N_IN*DATA_W | Input words, channel i at [i*DATA_W +: DATA_W] |
| in_stop | output | N_IN | Hold-off toward input channel i (slot occupied) |
| out_stop | input | M_OUT | Stall from output channel j |
| out_valid | output | M_OUT | Token produced on output channel j |
| out_data | output | M_OUT*DATA_W | Output words, channel j at [j*DATA_W +: DATA_W] |

## Verification
The case that needs care is a channel that is being held off while the wrapper fires. In that cycle the parked token is consumed, and its `in_stop` stays high. A late channel's live token is consumed at the same time with its `in_stop` low.

This case is provoked in two ways:
- a directed sequence parks a token on one channel and delivers the other channel's token in a later cycle;
- random arrival skew and random output stalls produce the same overlap many times.

Each cycle, the bench predicts slot occupancy from its own count of tokens sent against firings. It then checks `in_stop`, `out_valid` and the word that identifies which token of each input was merged.

// File: rtl/lis_shell_pkg.sv
package lis_shell_pkg;

   typedef enum logic {
      COMB_SUM = 1'b0,
      COMB_XOR = 1'b1
   } comb_e;

endpackage

// File: rtl/lis_in_slot.sv
module lis_in_slot #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              fire,
   output logic              avail,
   output logic              stop_up,
   output logic [DATA_W-1:0] core_word
);

   logic              full_q;
   logic [DATA_W-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         data_q <= '0;
      end else if (fire) begin
         full_q <= 1'b0;
      end else if (in_valid && !full_q) begin
         full_q <= 1'b1;
         data_q <= in_data;
      end
   end

   assign avail     = full_q | in_valid;
   assign stop_up   = full_q;
   assign core_word = full_q ? data_q : in_data;

   // R4: a token that arrives while nothing fires is parked
   p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !full_q && !fire) |=> (full_q && data_q == $past(in_data)));

   // R6: a firing empties the slot
   p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !full_q);

   // R5: a parked token stays, unchanged, until it is consumed
   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (full_q && !fire) |=> (full_q && $stable(data_q)));

   // R5: the upstream side never pushes into an occupied slot
   p_env_no_push_r5: assert property (@(posedge clk) disable iff (!rst_n)
      stop_up |-> !in_valid);

endmodule

// File: rtl/lis_fire_ctrl.sv
module lis_fire_ctrl #(
   parameter int N_IN  = 2,
   parameter int M_OUT = 2
) (
   input  logic [N_IN-1:0]  avail,
   input  logic [M_OUT-1:0] out_stop,
   output logic             fire,
   output logic [M_OUT-1:0] out_valid
);

   logic all_avail;
   logic any_stall;

   assign all_avail = &avail;
   assign any_stall = |out_stop;
   assign fire      = all_avail & ~any_stall;
   assign out_valid = {M_OUT{fire}};

endmodule

// File: rtl/lis_core_stub.sv
module lis_core_stub
   import lis_shell_pkg::*;
#(
   parameter int    N_IN    = 2,
   parameter int    M_OUT   = 2,
   parameter int    DATA_W  = 16,
   parameter comb_e COMBINE = COMB_SUM
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     fire,
   input  logic [N_IN*DATA_W-1:0]   core_in,
   output logic [M_OUT*DATA_W-1:0]  out_data
);

   logic [DATA_W-1:0] cnt_q;
   logic [DATA_W-1:0] merged;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else if (fire) cnt_q <= cnt_q + 1'b1;
   end

   generate
      if (COMBINE == COMB_XOR) begin : g_xor
         always_comb begin
            merged = '0;
            for (int i = 0; i < N_IN; i++) merged = merged ^ core_in[i*DATA_W +: DATA_W];
         end
      end else begin : g_sum
         always_comb begin
            merged = '0;
            for (int i = 0; i < N_IN; i++) merged = merged + core_in[i*DATA_W +: DATA_W];
         end
      end
   endgenerate

   generate
      for (genvar j = 0; j < M_OUT; j++) begin : g_out
         assign out_data[j*DATA_W +: DATA_W] = merged + cnt_q + DATA_W'(j);
      end
   endgenerate

   // R8: the core's state advances once per firing
   p_cnt_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> (cnt_q == $past(cnt_q) + DATA_W'(1)));

   // R8: the core's state is frozen while paused
   p_cnt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> $stable(cnt_q));

endmodule

// File: rtl/lis_shell.sv
module lis_shell
   import lis_shell_pkg::*;
#(
   parameter int    N_IN    = 2,
   parameter int    M_OUT   = 2,
   parameter int    DATA_W  = 16,
   parameter comb_e COMBINE = COMB_SUM
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N_IN-1:0]         in_valid,
   input  logic [N_IN*DATA_W-1:0]  in_data,
   output logic [N_IN-1:0]         in_stop,
   input  logic [M_OUT-1:0]        out_stop,
   output logic [M_OUT-1:0]        out_valid,
   output logic [M_OUT*DATA_W-1:0] out_data
);

   localparam int IN_BITS = N_IN * DATA_W;

   generate
      if (N_IN < 1)   begin : g_bad_n  $error("N_IN must be at least 1");   end
      if (M_OUT < 1)  begin : g_bad_m  $error("M_OUT must be at least 1");  end
      if (DATA_W < 1) begin : g_bad_w  $error("DATA_W must be at least 1"); end
   endgenerate

   logic [N_IN-1:0]    avail;
   logic [IN_BITS-1:0] core_in;
   logic               fire;

   generate
      for (genvar i = 0; i < N_IN; i++) begin : g_slot
         lis_in_slot #(.DATA_W(DATA_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (in_valid[i]),
            .in_data   (in_data[i*DATA_W +: DATA_W]),
            .fire      (fire),
            .avail     (avail[i]),
            .stop_up   (in_stop[i]),
            .core_word (core_in[i*DATA_W +: DATA_W])
         );
      end
   endgenerate

   lis_fire_ctrl #(.N_IN(N_IN), .M_OUT(M_OUT)) u_fire (
      .avail     (avail),
      .out_stop  (out_stop),
      .fire      (fire),
      .out_valid (out_valid)
   );

   lis_core_stub #(.N_IN(N_IN), .M_OUT(M_OUT), .DATA_W(DATA_W), .COMBINE(COMBINE)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .fire     (fire),
      .core_in  (core_in),
      .out_data (out_data)
   );

   // R2: output valids always agree
   p_equal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid == '0) || (&out_valid));

   // R3: a stall on any output suppresses every output valid
   p_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (|out_stop) |-> (out_valid == '0));

   // R1: a firing needs a token on every input, live or parked
   p_all_tokens_r1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[0] |-> (&(in_valid | in_stop)));

endmodule

// File: tb/lis_shell_tb_top.sv
`timescale 1ns/1ps
module lis_shell_tb_top;

   localparam int N = 2;
   localparam int M = 2;
   localparam int W = 16;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [N-1:0]   in_valid = '0;
   logic [N*W-1:0] in_data = '0;
   logic [N-1:0]   in_stop;
   logic [M-1:0]   out_stop = '0;
   logic [M-1:0]   out_valid;
   logic [M*W-1:0] out_data;

   int errors = 0;
   int checks = 0;
   int sent [N];
   int fires = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   lis_shell #(.N_IN(N), .M_OUT(M), .DATA_W(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_stop(in_stop), .out_stop(out_stop), .out_valid(out_valid), .out_data(out_data)
   );

   function automatic logic [W-1:0] tok_word(int ch, int seq);
      return W'(ch * 4096 + (seq % 4096));
   endfunction

   function automatic logic [W-1:0] exp_out(int k, int j);
      logic [W-1:0] s = '0;
      for (int i = 0; i < N; i++) s = s + tok_word(i, k);
      return s + W'(k) + W'(j);
   endfunction

   task automatic check(bit ok, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   task automatic step(logic [N-1:0] v_req, logic [M-1:0] s, string tag);
      logic [N-1:0] held, v;
      bit exp_fire;
      @(negedge clk);
      for (int i = 0; i < N; i++) begin
         held[i] = (sent[i] > fires);
         v[i] = v_req[i] & ~held[i];
         in_data[i*W +: W] = tok_word(i, sent[i]);
      end
      in_valid = v;
      out_stop = s;
      #1;
      exp_fire = (&(held | v)) && (s == '0);
      check(out_valid == {M{exp_fire}}, {tag, " R1 R2 R3 out_valid"}, int'(out_valid), int'({M{exp_fire}}));
      check(in_stop == held, {tag, " R5 in_stop"}, int'(in_stop), int'(held));
      if (exp_fire)
         for (int j = 0; j < M; j++)
            check(out_data[j*W +: W] == exp_out(fires, j), {tag, " R7 R8 R10 out_data"},
                  int'(out_data[j*W +: W]), int'(exp_out(fires, j)));
      for (int i = 0; i < N; i++) sent[i] += int'(v[i]);
      if (exp_fire) fires++;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      for (int i = 0; i < N; i++) sent[i] = 0;
      repeat (3) @(posedge clk);
      #1;
      check(in_stop == '0, "R9 reset in_stop", int'(in_stop), 0);
      check(out_valid == '0, "R9 reset out_valid", int'(out_valid), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // simultaneous arrival: fires at once, first firing count is zero (R9)
      step(2'b11, 2'b00, "R9 together");
      // ch0 early: parked (R4), then ch1 arrives and fires with ch0 held (R5)
      step(2'b01, 2'b00, "R4 early0");
      step(2'b00, 2'b00, "R4 wait");
      step(2'b10, 2'b00, "R5 late1");
      // slots cleared after firing (R6)
      step(2'b00, 2'b00, "R6 cleared");
      // both parked while output stalls, then release with no live input (R7)
      step(2'b11, 2'b01, "R3 stall");
      step(2'b00, 2'b10, "R3 stall2");
      step(2'b00, 2'b00, "R7 release");
      step(2'b00, 2'b00, "R6 empty");
      // ch1 early, ch0 arrives during stall, then release
      step(2'b10, 2'b00, "R4 early1");
      step(2'b01, 2'b11, "R3 stall3");
      step(2'b00, 2'b00, "R10 release2");

      // random skew and stalls
      for (int c = 0; c < 3000; c++) begin
         logic [N-1:0] v;
         logic [M-1:0] s;
         for (int i = 0; i < N; i++) v[i] = ($urandom % 2) == 0;
         for (int j = 0; j < M; j++) s[j] = ($urandom % 4) == 0;
         step(v, s, "R10 random");
      end
      // drain: no stalls, no new tokens beyond balancing
      for (int c = 0; c < 4; c++) step('1, '0, "R10 drain");
      for (int i = 0; i < N; i++)
         check(sent[i] - fires <= 1, "R10 balance", sent[i] - fires, 0);
      check(fires > 100, "R1 firing rate", fires, 101);

      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule